// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs a 14-bit sampling converter with a parallel data bus. For each sample it lowers the chip-select line. After a set-up time it pulses the convert-start line low. It then watches the converter's active-low busy flag go low and come back high. Next it pulses the read strobe and captures the bus. The captured word appears on `sample_o` with a one-clock `sample_vld_o` strobe and stays there until the next read. Every delay is a whole number of system-clock cycles, set by a parameter. Each parameter is sized for a 10 ns clock.

On the user side there are two ways to request conversions. A one-cycle `start_i` gives a single conversion. A held `run_i` gives back-to-back conversions. A two-bit `pwr_req_i` asks for a low-power mode. In nap mode, shutdown is driven low while chip-select is low. In sleep mode, shutdown is driven low while chip-select is high. When the request is dropped, a timed wake-up phase runs before any new conversion may start. If busy never completes, a timeout returns the sequencer to idle and flags an error.

The states are ST_IDLE, ST_PD_SET, ST_PD, ST_WAKE, ST_SETUP, ST_CONV, ST_WAIT, ST_READ and ST_GAP. The transitions are:
- IDLE→PD_SET on a power request.
- IDLE→SETUP on start or run.
- PD_SET→PD after T_CS cycles.
- PD→WAKE when the request returns to 00.
- WAKE→IDLE after T_WAKE cycles.
- SETUP→CONV after T_CS cycles.
- CONV→WAIT after T_CLO cycles.
- WAIT→READ when busy has been seen low and is high again.
- WAIT→IDLE on timeout.
- READ→GAP after T_RD cycles.
- GAP→IDLE after T_GAP cycles.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `adc_cs_n_o`, `adc_convst_n_o`, `adc_rd_n_o` and `adc_shdn_n_o` are all 1, and `sample_vld_o`, `busy_tmo_o` and `sample_o` are 0.
- R2: A start or run request seen in ST_IDLE with `pwr_req_i`=00 drives `adc_cs_n_o` low for exactly T_CS cycles before `adc_convst_n_o` falls. Chip-select then stays low until the end of ST_GAP.
- R3: `adc_convst_n_o` stays low for exactly T_CLO cycles and is then released. T_CLO must not exceed EARLY_REL cycles, the early-release window. Convert-start never rises later than EARLY_REL low cycles unless busy is high.
- R4: `adc_rd_n_o` falls only after busy has been seen low and then high again. It stays low T_RD cycles. The bus is captured on the last low cycle.
- R5: After read, T_GAP cycles pass with only chip-select low, then one ST_IDLE cycle. A held `run_i` repeats conversions this way.
- R6: If no completed busy cycle is seen within T_TMO cycles of `adc_convst_n_o` falling, `busy_tmo_o` pulses for one cycle, chip-select returns high, and no sample is issued.
- R7: Power requests take priority over start in ST_IDLE. With `pwr_req_i`=01 (nap), chip-select goes low. With bit 1 set (10 or 11, sleep), chip-select stays high. In both cases `adc_shdn_n_o` falls T_CS cycles later.
- R8: When `pwr_req_i` returns to 00, `adc_shdn_n_o` rises and chip-select is high for T_WAKE cycles. Start requests in that window are dropped, and no convert-start falls before it ends.
- R9: `start_i` and `run_i` have no effect outside ST_IDLE. A request made during a conversion or a power-down is not queued.
- R10: `sample_o` equals the 14-bit bus word unchanged, as a two's-complement value. Examples: 14'h2000 is most negative and 14'h1FFF is most positive. `sample_vld_o` is high for one clock per read, and `sample_o` changes only when the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Single-conversion request |
| run_i | input | 1 | Continuous-conversion request while high |
| pwr_req_i | input | 2 | 00 awake, 01 nap, 1x sleep |
| adc_busy_n_i | input | 1 | Converter busy flag, low while converting |
| adc_data_i | input | DW (14) | Converter parallel data bus |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_convst_n_o | output | 1 | Convert start, falling edge starts conversion |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_shdn_n_o | output | 1 | Shutdown, active low |
| sample_o | output | DW (14) | Last captured sample, two's complement |
| sample_vld_o | output | 1 | One-cycle strobe for a new sample |
| busy_tmo_o | output | 1 | One-cycle busy-timeout error |

## Verification
The assertions assume that busy is synchronous to `clk`. They also assume that busy goes low only after a convert-start fall and rises again within T_TMO cycles unless the converter hangs. The bench's converter model is clocked by the same clock, so it meets these assumptions. It drops busy two cycles after it sees the fall and raises busy 100 cycles later. A hang flag holds busy low to force the timeout case. All requests are driven just after a rising edge. That way each request is seen whole at the next edge, including requests made in states where they must be ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PD_SET,
        ST_PD,
        ST_WAKE,
        ST_SETUP,
        ST_CONV,
        ST_WAIT,
        ST_READ,
        ST_GAP
    } seq_state_t;

    localparam logic [1:0] PWR_AWAKE = 2'b00;
    localparam logic [1:0] PWR_NAP   = 2'b01;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sample_hold.sv
module sample_hold #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q,
    output logic          vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            vld <= cap;
            if (cap)
                q <= d;
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld); // R10

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DW        = 14,
    parameter int T_CS      = 4,
    parameter int T_CLO     = 4,
    parameter int EARLY_REL = 64,
    parameter int T_RD      = 4,
    parameter int T_GAP     = 4,
    parameter int T_WAKE    = 40,
    parameter int T_TMO     = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          run_i,
    input  logic [1:0]    pwr_req_i,
    input  logic          adc_busy_n_i,
    input  logic [DW-1:0] adc_data_i,
    output logic          adc_cs_n_o,
    output logic          adc_convst_n_o,
    output logic          adc_rd_n_o,
    output logic          adc_shdn_n_o,
    output logic [DW-1:0] sample_o,
    output logic          sample_vld_o,
    output logic          busy_tmo_o
);
    localparam int MAXC = imax(imax(imax(T_TMO, T_WAKE), imax(EARLY_REL, T_CS)),
                               imax(imax(T_CLO, T_RD), T_GAP));
    localparam int CW = $clog2(MAXC + 1);

    seq_state_t state, state_n;
    logic       ph_zero, tmo_zero, ph_load, tmo_load;
    logic [CW-1:0] ph_val;
    logic       seen_low, sleep_r, conv_done, capture;

    assign conv_done = seen_low && adc_busy_n_i;
    assign ph_load   = (state_n != state);
    assign tmo_load  = ph_load && (state_n == ST_CONV);
    assign capture   = (state == ST_READ) && ph_zero;

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (pwr_req_i != PWR_AWAKE)  state_n = ST_PD_SET;
                       else if (start_i || run_i)   state_n = ST_SETUP;
            ST_PD_SET: if (ph_zero)                 state_n = ST_PD;
            ST_PD:     if (pwr_req_i == PWR_AWAKE)  state_n = ST_WAKE;
            ST_WAKE:   if (ph_zero)                 state_n = ST_IDLE;
            ST_SETUP:  if (ph_zero)                 state_n = ST_CONV;
            ST_CONV:   if (ph_zero)                 state_n = ST_WAIT;
            ST_WAIT:   if (conv_done)               state_n = ST_READ;
                       else if (tmo_zero)           state_n = ST_IDLE;
            ST_READ:   if (ph_zero)                 state_n = ST_GAP;
            ST_GAP:    if (ph_zero)                 state_n = ST_IDLE;
            default:                                state_n = ST_IDLE;
        endcase
    end

    // phase length for the state being entered
    always_comb begin
        unique case (state_n)
            ST_PD_SET, ST_SETUP: ph_val = CW'(T_CS - 1);
            ST_WAKE:             ph_val = CW'(T_WAKE - 1);
            ST_CONV:             ph_val = CW'(T_CLO - 1);
            ST_READ:             ph_val = CW'(T_RD - 1);
            ST_GAP:              ph_val = CW'(T_GAP - 1);
            default:             ph_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_low <= 1'b0;
            sleep_r  <= 1'b0;
        end else begin
            if (tmo_load)
                seen_low <= 1'b0;
            else if (state == ST_CONV || state == ST_WAIT)
                seen_low <= seen_low || !adc_busy_n_i;
            if (state == ST_IDLE && state_n == ST_PD_SET)
                sleep_r <= pwr_req_i[1];
        end
    end

    // outputs
    always_comb begin
        adc_cs_n_o     = 1'b1;
        adc_convst_n_o = 1'b1;
        adc_rd_n_o     = 1'b1;
        adc_shdn_n_o   = 1'b1;
        busy_tmo_o     = 1'b0;
        unique case (state)
            ST_PD_SET:                 adc_cs_n_o = sleep_r;
            ST_PD: begin               adc_cs_n_o = sleep_r; adc_shdn_n_o = 1'b0; end
            ST_SETUP, ST_GAP:          adc_cs_n_o = 1'b0;
            ST_CONV: begin             adc_cs_n_o = 1'b0; adc_convst_n_o = 1'b0; end
            ST_WAIT: begin             adc_cs_n_o = 1'b0; busy_tmo_o = !conv_done && tmo_zero; end
            ST_READ: begin             adc_cs_n_o = 1'b0; adc_rd_n_o = 1'b0; end
            default: ;
        endcase
    end

    seq_timer #(.W(CW)) u_phase (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    seq_timer #(.W(CW)) u_tmo (
        .clk(clk), .rst(rst), .load(tmo_load), .load_val(CW'(T_TMO - 1)), .zero(tmo_zero)
    );

    sample_hold #(.DW(DW)) u_hold (
        .clk(clk), .rst(rst), .cap(capture), .d(adc_data_i),
        .q(sample_o), .vld(sample_vld_o)
    );

    // pin-timing observers for the assertions
    logic [CW-1:0] cs_lo_cnt, cv_lo_cnt, awake_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_lo_cnt <= '0;
            cv_lo_cnt <= '0;
            awake_cnt <= '1;
        end else begin
            cs_lo_cnt <= adc_cs_n_o     ? '0 : ((cs_lo_cnt == '1) ? cs_lo_cnt : cs_lo_cnt + 1'b1);
            cv_lo_cnt <= adc_convst_n_o ? '0 : ((cv_lo_cnt == '1) ? cv_lo_cnt : cv_lo_cnt + 1'b1);
            awake_cnt <= !adc_shdn_n_o  ? '0 : ((awake_cnt == '1) ? awake_cnt : awake_cnt + 1'b1);
        end
    end

    AST_CS_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_convst_n_o) |-> (!adc_cs_n_o && cs_lo_cnt >= CW'(T_CS))); // R2
    AST_CONVST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_convst_n_o) |-> (cv_lo_cnt >= CW'(T_CLO)) &&
                                  (cv_lo_cnt <= CW'(EARLY_REL) || adc_busy_n_i)); // R3
    AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_rd_n_o) |-> (adc_busy_n_i && !adc_cs_n_o)); // R4
    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (rst)
        !sample_vld_o |-> $stable(sample_o)); // R10
    AST_TMO_IDLE: assert property (@(posedge clk) disable iff (rst)
        busy_tmo_o |=> (adc_cs_n_o && !sample_vld_o)); // R6
    AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !adc_shdn_n_o |-> (adc_convst_n_o && adc_rd_n_o)); // R7
    AST_WAKE_TIME: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_convst_n_o) |-> (awake_cnt >= CW'(T_WAKE))); // R8

endmodule

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;
    localparam int DW = 14, T_CS = 4, T_CLO = 4, T_RD = 4, T_GAP = 4;
    localparam int T_WAKE = 40, T_TMO = 200, CONV_CYC = 100;
    localparam int P_IDLE = 0, P_PDSET = 1, P_PD = 2, P_WAKE = 3, P_SETUP = 4,
                   P_CONV = 5, P_WAIT = 6, P_READ = 7, P_GAP = 8;

    logic clk = 0, rst = 1, start = 0, run = 0;
    logic [1:0] pwr = 2'b00;
    logic busy_n = 1;
    logic [DW-1:0] bus, smp;
    logic cs_n, cv_n, rd_n, sd_n, vld, err;

    always #5 clk = ~clk;

    adc_conv_seq u0 (
        .clk(clk), .rst(rst), .start_i(start), .run_i(run), .pwr_req_i(pwr),
        .adc_busy_n_i(busy_n), .adc_data_i(bus), .adc_cs_n_o(cs_n),
        .adc_convst_n_o(cv_n), .adc_rd_n_o(rd_n), .adc_shdn_n_o(sd_n),
        .sample_o(smp), .sample_vld_o(vld), .busy_tmo_o(err)
    );

    // converter stand-in
    logic [DW-1:0] dev_val = '0, dev_out = '0;
    logic hang = 0, prev_cv = 1;
    int adc_t = 0;
    assign bus = rd_n ? 14'h0155 : dev_out;
    always @(posedge clk) begin
        prev_cv <= cv_n;
        if (prev_cv && !cv_n && adc_t == 0) adc_t <= 1;
        else if (adc_t > 0) begin
            adc_t <= adc_t + 1;
            if (adc_t == 2) busy_n <= 0;
            if (adc_t >= CONV_CYC && !hang) begin
                busy_n <= 1; adc_t <= 0; dev_out <= dev_val;
            end
        end
    end

    // behavioural reference
    int ph = P_IDLE, cnt = 0, tmo = 0;
    bit seen = 0, slp = 0, m_vld = 0;
    logic [DW-1:0] m_smp = '0;
    function automatic int len_of(input int p);
        case (p)
            P_PDSET, P_SETUP: return T_CS - 1;
            P_WAKE: return T_WAKE - 1;
            P_CONV: return T_CLO - 1;
            P_READ: return T_RD - 1;
            P_GAP:  return T_GAP - 1;
            default: return 0;
        endcase
    endfunction
    always @(posedge clk) begin
        int nph;
        if (rst) begin
            ph = P_IDLE; cnt = 0; tmo = 0; seen = 0; slp = 0; m_vld = 0; m_smp = '0;
        end else begin
            nph = ph;
            case (ph)
                P_IDLE:  if (pwr != 0) nph = P_PDSET; else if (start || run) nph = P_SETUP;
                P_PDSET: if (cnt == 0) nph = P_PD;
                P_PD:    if (pwr == 0) nph = P_WAKE;
                P_WAKE:  if (cnt == 0) nph = P_IDLE;
                P_SETUP: if (cnt == 0) nph = P_CONV;
                P_CONV:  if (cnt == 0) nph = P_WAIT;
                P_WAIT:  if (seen && busy_n) nph = P_READ; else if (tmo == 0) nph = P_IDLE;
                P_READ:  if (cnt == 0) nph = P_GAP;
                P_GAP:   if (cnt == 0) nph = P_IDLE;
                default: nph = P_IDLE;
            endcase
            m_vld = (ph == P_READ && cnt == 0);
            if (m_vld) m_smp = dev_out;
            if (ph == P_IDLE && nph == P_PDSET) slp = pwr[1];
            if (nph == P_CONV && ph != P_CONV) begin seen = 0; tmo = T_TMO - 1; end
            else begin
                if (ph == P_CONV || ph == P_WAIT) seen = seen || !busy_n;
                if (tmo > 0) tmo--;
            end
            if (nph != ph) cnt = len_of(nph); else if (cnt > 0) cnt--;
            ph = nph;
        end
    end

    int n_cmp = 0, n_bad = 0, cyc = 0, n_vld = 0, n_err = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit e_cs, e_cv, e_rd, e_sd, e_err;
        cyc++;
        if (vld) n_vld++;
        if (err) n_err++;
        if (cyc > 2) begin
            e_cs  = !(ph inside {P_SETUP, P_CONV, P_WAIT, P_READ, P_GAP}) &&
                    !((ph == P_PDSET || ph == P_PD) && !slp);
            e_cv  = (ph != P_CONV);
            e_rd  = (ph != P_READ);
            e_sd  = (ph != P_PD);
            e_err = (ph == P_WAIT) && !(seen && busy_n) && tmo == 0;
            chk(cs_n == e_cs, "R2 cs_n", cs_n, e_cs);
            chk(cv_n == e_cv, "R3 convst_n", cv_n, e_cv);
            chk(rd_n == e_rd, "R4 rd_n", rd_n, e_rd);
            chk(sd_n == e_sd, "R7 shdn_n", sd_n, e_sd);
            chk(err == e_err, "R6 busy_tmo", err, e_err);
            chk(vld == m_vld, "R10 sample_vld", vld, m_vld);
            chk(smp == m_smp, "R10 sample", smp, m_smp);
        end
        if (cyc > 100000) begin
            chk(0, "watchdog", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask
    task automatic pulse_start();
        start = 1; cycles(1); start = 0;
    endtask

    initial begin
        int base;
        cycles(3);
        @(negedge clk);
        chk(cs_n && cv_n && rd_n && sd_n && !vld && !err && smp == 0, "R1 reset state", {cs_n, cv_n, rd_n, sd_n}, 4'hF);
        @(posedge clk); #1 rst = 0;
        @(negedge clk);
        chk(cs_n && cv_n && rd_n && sd_n && !vld && smp == 0, "R1 after reset", {cs_n, cv_n, rd_n, sd_n}, 4'hF);
        @(posedge clk); #1;

        dev_val = 14'h2000; pulse_start(); cycles(200);
        chk(n_vld == 1, "R4 one read", n_vld, 1);
        chk(smp == 14'h2000, "R10 most negative", smp, 14'h2000);

        dev_val = 14'h1FFF; pulse_start(); cycles(30); pulse_start(); cycles(200);
        chk(n_vld == 2, "R9 start in conversion ignored", n_vld, 2);
        chk(smp == 14'h1FFF, "R10 most positive", smp, 14'h1FFF);

        base = n_vld; dev_val = 14'h0AAA; run = 1; cycles(360); run = 0; cycles(200);
        chk(n_vld - base >= 3, "R5 continuous run", n_vld - base, 3);

        base = n_vld; hang = 1; pulse_start(); cycles(250);
        chk(n_err == 1, "R6 timeout flagged", n_err, 1);
        chk(n_vld == base, "R6 no sample on timeout", n_vld, base);
        hang = 0; cycles(120);

        base = n_vld; pwr = 2'b01; pulse_start(); cycles(20);
        chk(!sd_n && !cs_n, "R7 nap pins", {sd_n, cs_n}, 0);
        pulse_start(); cycles(10);
        chk(cv_n && n_vld == base, "R9 start in power-down ignored", cv_n, 1);
        pwr = 2'b00; cycles(5);
        chk(sd_n && cs_n, "R8 wake pins", {sd_n, cs_n}, 3);
        pulse_start(); cycles(45);
        chk(n_vld == base, "R8 start during wake dropped", n_vld, base);
        dev_val = 14'h0001; pulse_start(); cycles(200);
        chk(n_vld == base + 1, "R8 converts after wake", n_vld, base + 1);

        pwr = 2'b10; cycles(20);
        chk(!sd_n && cs_n, "R7 sleep pins", {sd_n, cs_n}, 1);
        pwr = 2'b00; cycles(60);
        chk(sd_n && cs_n && n_err == 1, "R8 wake from sleep", {sd_n, cs_n}, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule